// File: doc/BRIEF.md
# SIMD Rounding Shift-Accumulate Unit

This block is the shift stage of a vector execution pipe. It takes a 128-bit source vector and a 128-bit destination vector and shifts every lane by an immediate. Lanes are 8, 16, 32 or 64 bits wide. A right shift can be signed or unsigned and rounding or truncating, and it can add its result into the existing destination lane. The block also does a plain left shift by immediate and a left shift that inserts into the destination.

The operation can cover the whole 128-bit register, only its lower 64-bit half, or only lane 0 (scalar form). The unused part of the result reads as zero. The instruction decoder drives one request per cycle with a valid strobe. One cycle later the registered result appears, together with a one-cycle valid pulse.

Top module: `simd_shift_unit`

## Requirements
- R1: The size code z (0..3) selects a lane width of 8<<z bits. In the full form there are 128/(8<<z) lanes. Each result lane depends only on the same lane of the source and destination.
- R2: Op code 0 is a right shift. With signed_i=0, round_i=0 and accum_i=0, each lane is the source lane shifted right logically by shamt_i, where shamt_i is 1 to the lane width.
- R3: With signed_i=1, the right shift is arithmetic, so vacated bits take the lane's sign bit.
- R4: With round_i=1, the right-shift result gets bit (shamt_i-1) of the source lane added to it. This is the same as adding 1<<(shamt_i-1) before the shift.
- R5: A right shift by exactly the lane width gives all sign bits for signed lanes and zero for unsigned lanes, before any rounding is added.
- R6: With accum_i=1, the right-shift result is added to the destination lane. The sum wraps modulo 2^lane-width and does not saturate.
- R7: For 64-bit lanes, the rounding increment keeps its carry. For example, an unsigned rounding shift right by 1 of 0xFFFF_FFFF_FFFF_FFFF gives 0x8000_0000_0000_0000.
- R8: Op code 1 is a left shift. Each lane is the source lane shifted left by shamt_i, where shamt_i is 0 to the lane width minus 1. Bits shifted past the lane top are lost.
- R9: Op code 2 is shift-left-insert. Each lane is (source << shamt_i) with the low shamt_i bits taken from the destination lane. When shamt_i is 0, no destination bit survives.
- R10: Form code 1 (64-bit register form) computes only the lanes in bits 63:0. Result bits 127:64 are zero.
- R11: Form code 2 (scalar form) computes only lane 0. Every other result bit is zero. Form code 0 is the full 128-bit form.
- R12: res_valid_o is high for exactly one cycle, on the cycle after each cycle in which req_valid_i is high. res_o holds its value while no request arrives.
- R13: While reset is asserted and after it is released, res_valid_o is 0 and res_o is 0 until the first request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| src_i | input | 128 | Source vector |
| dst_i | input | 128 | Current destination vector |
| size_i | input | 2 | Lane size code, width 8<<size |
| shamt_i | input | 7 | Shift immediate |
| op_i | input | 2 | 0 right shift, 1 left shift, 2 shift-left-insert |
| signed_i | input | 1 | Signed right shift |
| round_i | input | 1 | Rounding right shift |
| accum_i | input | 1 | Accumulate into destination lane |
| form_i | input | 2 | 0 full, 1 lower-half register, 2 scalar |
| res_valid_o | output | 1 | Result valid pulse |
| res_o | output | 128 | Registered result |

## Verification
The assertions assume that op_i and form_i never carry code 3. They also assume shamt_i is in range for the operation: 1 to the lane width for right shifts, and 0 to the lane width minus 1 for left shifts and inserts. The insert-mask property relies on this, and on a 64-bit lane using the low 64 result bits. The stimulus draws every immediate from that legal range for the chosen size. Among those values it uses both ends of each range: 0, 1, width-1 and width. It drives only the three defined op and form codes.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    OP_SHR = 2'd0,
    OP_SHL = 2'd1,
    OP_SLI = 2'd2
  } ssu_op_e;

  typedef enum logic [1:0] {
    FORM_FULL   = 2'd0,
    FORM_HALF   = 2'd1,
    FORM_SCALAR = 2'd2
  } ssu_form_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned SHAMT_W   = 7;
endpackage

// File: rtl/ssu_lane.sv
module ssu_lane
  import ssu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]         src_i,
  input  logic [W-1:0]         dst_i,
  input  logic [SHAMT_W-1:0]   shamt_i,
  input  ssu_op_e              op_i,
  input  logic                 sgn_i,
  input  logic                 rnd_i,
  input  logic                 acc_i,
  output logic [W-1:0]         res_o
);
  localparam int unsigned EW = W + 1;
  localparam logic [SHAMT_W-1:0] AMT_MAX = SHAMT_W'(W);

  logic [EW-1:0]      ext;
  logic [SHAMT_W-1:0] amt;
  logic [EW-1:0]      shr_full;
  logic [EW-1:0]      rb_vec;
  logic               rnd_bit;
  logic [W-1:0]       acc_term;
  logic [W-1:0]       shr_res;
  logic [EW-1:0]      shl_full;
  logic [EW-1:0]      keep_full;
  logic [W-1:0]       sli_res;

  always_comb begin
    // one guard bit so a shift by the full lane width is still defined
    ext = {sgn_i & src_i[W-1], src_i};
    amt = (shamt_i > AMT_MAX) ? AMT_MAX : shamt_i;
    if (sgn_i) begin
      shr_full = $signed(ext) >>> amt;
    end else begin
      shr_full = ext >> amt;
    end
    // rounding: add the last bit shifted out, after the shift (no carry loss)
    if (rnd_i && (amt != '0)) begin
      rb_vec = ext >> (amt - SHAMT_W'(1));
    end else begin
      rb_vec = '0;
    end
    rnd_bit  = rb_vec[0];
    acc_term = acc_i ? dst_i : '0;
    shr_res  = shr_full[W-1:0] + {{(W-1){1'b0}}, rnd_bit} + acc_term;

    shl_full  = {1'b0, src_i} << amt;
    keep_full = ({{W{1'b0}}, 1'b1} << amt) - EW'(1);
    sli_res   = shl_full[W-1:0] | (dst_i & keep_full[W-1:0]);

    unique case (op_i)
      OP_SHL:  res_o = shl_full[W-1:0];
      OP_SLI:  res_o = sli_res;
      default: res_o = shr_res;
    endcase
  end
endmodule

// File: rtl/ssu_bank.sv
module ssu_bank
  import ssu_pkg::*;
#(
  parameter int unsigned VW = 128,
  parameter int unsigned W  = 8
) (
  input  logic [VW-1:0]        src_i,
  input  logic [VW-1:0]        dst_i,
  input  logic [SHAMT_W-1:0]   shamt_i,
  input  ssu_op_e              op_i,
  input  logic                 sgn_i,
  input  logic                 rnd_i,
  input  logic                 acc_i,
  input  ssu_form_e            form_i,
  output logic [VW-1:0]        res_o
);
  localparam int unsigned N      = VW / W;
  localparam int unsigned HALF_N = (N > 1) ? N / 2 : 1;

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam bit IN_LOW = (i < HALF_N);
    localparam bit IS_FIRST = (i == 0);
    logic [W-1:0] lane_res;
    logic         keep;

    ssu_lane #(.W(W)) u_lane (
      .src_i   (src_i[i*W +: W]),
      .dst_i   (dst_i[i*W +: W]),
      .shamt_i (shamt_i),
      .op_i    (op_i),
      .sgn_i   (sgn_i),
      .rnd_i   (rnd_i),
      .acc_i   (acc_i),
      .res_o   (lane_res)
    );

    always_comb begin
      unique case (form_i)
        FORM_HALF:   keep = IN_LOW;
        FORM_SCALAR: keep = IS_FIRST;
        default:     keep = 1'b1;
      endcase
    end

    assign res_o[i*W +: W] = keep ? lane_res : '0;
  end
endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
  import ssu_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [VEC_W-1:0]   src_i,
  input  logic [VEC_W-1:0]   dst_i,
  input  logic [1:0]         size_i,
  input  logic [6:0]         shamt_i,
  input  logic [1:0]         op_i,
  input  logic               signed_i,
  input  logic               round_i,
  input  logic               accum_i,
  input  logic [1:0]         form_i,
  output logic               res_valid_o,
  output logic [VEC_W-1:0]   res_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [VEC_W-1:0] bank_res [NUM_SIZES];
  logic [VEC_W-1:0] res_d;
  logic [VEC_W-1:0] res_q;
  logic             vld_d;
  logic             vld_q;
  ssu_op_e          op_t;
  ssu_form_e        form_t;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign op_t   = ssu_op_e'(op_i);
  assign form_t = ssu_form_e'(form_i);

  for (genvar z = 0; z < NUM_SIZES; z++) begin : g_size
    ssu_bank #(.VW(VEC_W), .W(8 << z)) u_bank (
      .src_i   (src_i),
      .dst_i   (dst_i),
      .shamt_i (shamt_i),
      .op_i    (op_t),
      .sgn_i   (signed_i),
      .rnd_i   (round_i),
      .acc_i   (accum_i),
      .form_i  (form_t),
      .res_o   (bank_res[z])
    );
  end

  always_comb begin
    vld_d = req_valid_i;
    res_d = res_q;
    if (req_valid_i) begin
      res_d = bank_res[size_i];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = vld_q;

  // R12
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid_i |=> res_valid_o);
  // R12
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid_i |=> (!res_valid_o && $stable(res_o)));
  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid_i && (form_i == FORM_HALF || form_i == FORM_SCALAR))
      |=> (res_o[VEC_W-1:HALF_W] == '0));
  // R11
  scalar_byte_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid_i && form_i == FORM_SCALAR && size_i == 2'd0)
      |=> (res_o[HALF_W-1:8] == '0));
  // R9
  insert_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (res_valid_o && $past(op_i) == OP_SLI && $past(size_i) == 2'd3 && $past(shamt_i) < 7'd64)
      |-> (((res_o[63:0] ^ $past(dst_i[63:0])) & ((64'd1 << $past(shamt_i[5:0])) - 64'd1)) == 64'd0));
  // R8
  shl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (res_valid_o && $past(op_i) == OP_SHL && $past(size_i) == 2'd3 && $past(shamt_i) < 7'd64)
      |-> ((res_o[63:0] & ((64'd1 << $past(shamt_i[5:0])) - 64'd1)) == 64'd0));
endmodule

// File: tb/tb_simd_shift_unit.sv
module tb_simd_shift_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [127:0] src = '0;
  logic [127:0] dst = '0;
  logic [1:0]   size = '0;
  logic [6:0]   shamt = '0;
  logic [1:0]   op = '0;
  logic         sgn = 1'b0;
  logic         rnd = 1'b0;
  logic         acc = 1'b0;
  logic [1:0]   form = '0;
  logic         res_valid;
  logic [127:0] res;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  simd_shift_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .src_i(src), .dst_i(dst),
    .size_i(size), .shamt_i(shamt), .op_i(op), .signed_i(sgn), .round_i(rnd),
    .accum_i(acc), .form_i(form), .res_valid_o(res_valid), .res_o(res)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent lane model built from the requirements
  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
      input int z, input int sh, input int o, input bit sg, input bit rd, input bit ac,
      input int f);
    int w = 8 << z;
    int n = (f == 2) ? 1 : ((f == 1) ? 64 / w : 128 / w);
    logic [127:0] out = '0;
    logic signed [129:0] m = (130'sd1 <<< w) - 130'sd1;
    for (int k = 0; k < n; k++) begin
      logic signed [129:0] a = 130'(s >> (k * w)) & m;
      logic signed [129:0] b = 130'(d >> (k * w)) & m;
      logic signed [129:0] v = (sg && a[w-1]) ? a - (130'sd1 <<< w) : a;
      logic signed [129:0] t;
      if (o == 0) begin
        t = v >>> sh;
        if (rd) t = t + ((v >>> (sh - 1)) & 130'sd1);
        if (ac) t = t + b;
      end else if (o == 1) begin
        t = a <<< sh;
      end else begin
        t = (a <<< sh) | (b & ((130'sd1 <<< sh) - 130'sd1));
      end
      out = out | (128'(t & m) << (k * w));
    end
    return out;
  endfunction

  task automatic run(input logic [127:0] s, input logic [127:0] d, input int z, input int sh,
      input int o, input bit sg, input bit rd, input bit ac, input int f);
    src = s; dst = d; size = 2'(z); shamt = 7'(sh); op = 2'(o);
    sgn = sg; rnd = rd; acc = ac; form = 2'(f); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 valid in reset", {127'd0, res_valid}, 128'd0);
    chk("R13 result in reset", res, 128'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 valid after release", {127'd0, res_valid}, 128'd0);
    chk("R13 result after release", res, 128'd0);
  endtask

  task automatic t_logical();
    run({16{8'hF0}}, '0, 0, 3, 0, 0, 0, 0, 0);
    chk("R2 logical byte shift", res, {16{8'h1E}});
    run({8{16'h8001}}, '0, 1, 1, 0, 0, 0, 0, 0);
    chk("R2 logical halfword shift", res, {8{16'h4000}});
  endtask

  task automatic t_arith();
    run({16{8'hF0}}, '0, 0, 3, 0, 1, 0, 0, 0);
    chk("R3 arithmetic byte shift", res, {16{8'hFE}});
    run({4{32'h8000_0000}}, '0, 2, 31, 0, 1, 0, 0, 0);
    chk("R3 arithmetic word shift", res, {4{32'hFFFF_FFFF}});
  endtask

  task automatic t_round();
    run({16{8'hF4}}, '0, 0, 3, 0, 1, 1, 0, 0);
    chk("R4 signed rounding", res, {16{8'hFF}});
    run({16{8'h0C}}, '0, 0, 3, 0, 0, 1, 0, 0);
    chk("R4 unsigned rounding", res, {16{8'h02}});
  endtask

  task automatic t_full_width();
    run({8{16'h8000}}, '0, 1, 16, 0, 1, 0, 0, 0);
    chk("R5 signed width shift", res, {8{16'hFFFF}});
    run({8{16'h8000}}, '0, 1, 16, 0, 1, 1, 0, 0);
    chk("R5 signed width shift rounded", res, '0);
    run({8{16'h8000}}, '0, 1, 16, 0, 0, 0, 0, 0);
    chk("R5 unsigned width shift", res, '0);
    run({8{16'h8000}}, '0, 1, 16, 0, 0, 1, 0, 0);
    chk("R5 unsigned width shift rounded", res, {8{16'h0001}});
  endtask

  task automatic t_accum();
    run({16{8'hFE}}, {16{8'h90}}, 0, 1, 0, 0, 0, 1, 0);
    chk("R6 accumulate wraps", res, {16{8'h0F}});
    run({16{8'h80}}, {16{8'h01}}, 0, 2, 0, 1, 0, 1, 0);
    chk("R6 signed accumulate", res, {16{8'hE1}});
  endtask

  task automatic t_carry();
    run({2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, 3, 1, 0, 0, 1, 0, 0);
    chk("R7 64-bit rounding carry", res, {2{64'h8000_0000_0000_0000}});
    run({2{64'h8000_0000_0000_0000}}, '0, 3, 64, 0, 0, 1, 0, 0);
    chk("R7 64-bit width shift rounded", res, {2{64'd1}});
  endtask

  task automatic t_shl();
    run({4{32'h1234_5678}}, '0, 2, 4, 1, 0, 0, 0, 0);
    chk("R8 left shift word", res, {4{32'h2345_6780}});
    run({2{64'hFFFF_0000_0000_0001}}, '0, 3, 63, 1, 0, 0, 0, 0);
    chk("R8 left shift top bit", res, {2{64'h8000_0000_0000_0000}});
  endtask

  task automatic t_insert();
    run({16{8'hFF}}, {16{8'hAD}}, 0, 3, 2, 0, 0, 0, 0);
    chk("R9 insert keeps low bits", res, {16{8'hFD}});
    run({16{8'h3C}}, {16{8'hFF}}, 0, 0, 2, 0, 0, 0, 0);
    chk("R9 insert shift zero", res, {16{8'h3C}});
  endtask

  task automatic t_half();
    run({16{8'hF0}}, '0, 0, 4, 0, 0, 0, 0, 1);
    chk("R10 half form", res, {64'd0, {8{8'h0F}}});
    run({4{32'h0000_0001}}, '0, 2, 1, 1, 0, 0, 0, 1);
    chk("R10 half form left", res, {64'd0, {2{32'h0000_0002}}});
  endtask

  task automatic t_scalar();
    run({16{8'hF0}}, '0, 0, 4, 0, 0, 0, 0, 2);
    chk("R11 scalar byte", res, {120'd0, 8'h0F});
    run({2{64'h10}}, {2{64'h1}}, 3, 4, 0, 0, 0, 1, 2);
    chk("R11 scalar doubleword", res, {64'd0, 64'h2});
  endtask

  task automatic t_lanes();
    logic [127:0] s = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    logic [127:0] d = 128'h8F7E_6D5C_4B3A_2918_0716_2534_4352_6170;
    for (int z = 0; z < 4; z++) begin
      int w = 8 << z;
      int shs[3] = '{1, w / 2 + 1, w};
      for (int j = 0; j < 3; j++) begin
        for (int fl = 0; fl < 8; fl++) begin
          run(s, d, z, shs[j], 0, fl[0], fl[1], fl[2], 0);
          chk($sformatf("R1 right z=%0d sh=%0d fl=%0d", z, shs[j], fl), res,
              model(s, d, z, shs[j], 0, fl[0], fl[1], fl[2], 0));
        end
        run(s, d, z, shs[j] - 1, 2, 0, 0, 0, 0);
        chk($sformatf("R1 insert z=%0d sh=%0d", z, shs[j] - 1), res,
            model(s, d, z, shs[j] - 1, 2, 0, 0, 0, 0));
        run(s, d, z, shs[j] - 1, 1, 0, 0, 0, 1);
        chk($sformatf("R1 left half z=%0d sh=%0d", z, shs[j] - 1), res,
            model(s, d, z, shs[j] - 1, 1, 0, 0, 0, 1));
      end
    end
  endtask

  task automatic t_timing();
    logic [127:0] held;
    src = {16{8'h40}}; dst = '0; size = 2'd0; shamt = 7'd2; op = 2'd0;
    sgn = 1'b0; rnd = 1'b0; acc = 1'b0; form = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 valid one cycle later", {127'd0, res_valid}, 128'd1);
    chk("R12 result with pulse", res, {16{8'h10}});
    held = res;
    src = '1; shamt = 7'd1;
    @(negedge clk);
    chk("R12 valid drops", {127'd0, res_valid}, 128'd0);
    repeat (2) @(negedge clk);
    chk("R12 result holds while idle", res, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_logical();
    t_arith();
    t_round();
    t_full_width();
    t_accum();
    t_carry();
    t_shl();
    t_insert();
    t_half();
    t_scalar();
    t_lanes();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule